// File: doc/BRIEF.md
# I2C Slave Register-Access Front End

This block is the serial-bus side of a small register-mapped peripheral. It watches an I2C bus through the system clock, picks out START and STOP conditions, and answers a fixed identification byte. That byte has a constant upper nibble and three address bits that the board sets with straps. After a match it takes a register-address byte into an internal pointer. It then either accepts a stream of write bytes or, after a repeated START with the read bit set, streams register contents back to the master.

On the register side the block drives a simple strobe bus: a one-cycle write strobe with address and data, and a one-cycle read request whose data the controller returns one clock later. The address output comes from a pointer that steps after every byte and wraps from the last address back to zero. A busy input from the controller makes the block refuse write data while a slow storage update is in flight. The register bus has no back-pressure. Each strobe is a single cycle, the controller must take it, and the bus timing (SCL at least 16 system clocks per period) leaves many idle cycles between strobes.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe`, `reg_wr`, `reg_rd` and `stop_pulse` are all low, and the block ignores the bus until a START (SDA falling while SCL is high).
- R2: The identification byte, sent MSB first, is accepted only when its upper seven bits equal binary 1010 followed by `dev_addr[2:0]`; bit 0 selects read (1) or write (0). A matching byte is ACKed. A non-matching byte is not ACKed, and SDA stays released until the next START.
- R3: In a write, the byte after the identification byte loads its low bits into the register pointer and is ACKed. Each later data byte is ACKed and produces exactly one `reg_wr` pulse carrying the current pointer and the byte, and the pointer then steps by one.
- R4: The pointer wraps from address 8 to address 0, in both write and read streams.
- R5: In a read (write-mode ID, address byte, repeated START, read-mode ID), the block fetches with a `reg_rd` pulse at the current pointer and shifts the byte out MSB first. It fetches and sends the next byte, pointer stepped, for as long as the master ACKs. A master NACK ends the stream.
- R6: A write data byte that completes while `nv_busy` is high is not ACKed and produces no `reg_wr`. The register keeps its old value, and the block ignores the bus until the next START or STOP.
- R7: A STOP (SDA rising while SCL is high) produces a one-cycle `stop_pulse`, releases SDA and returns the block to idle.
- R8: A START in the middle of a byte abandons that byte and restarts identification-byte reception.
- R9: `sda_oe` (1 pulls SDA low) changes only while SCL is low, except for the release caused by a START or STOP.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle, and `reg_rdata` is taken in the clock cycle that follows a `reg_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_addr | input | 3 | Strapped low bits of the identification byte |
| nv_busy | input | 1 | Controller busy; write data is refused while high |
| reg_addr | output | 4 | Register address for the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| stop_pulse | output | 1 | One-cycle pulse on each detected STOP |

## Verification
Every cycle, the assertions check the following: SDA only moves while SCL is low unless a START or STOP forced a release; the line stays released in idle and after a refusal; write strobes never follow a busy cycle; the two strobes never overlap; a STOP always lands the block in idle; and the pointer wraps from 8 to 0. Only the bench's bus scenarios can show the rest. That covers whether the right bytes are ACKed, whether data reaches the right register in the right order across the wrap, whether read streams return the stored bytes MSB first and stop on a NACK, and whether a mid-byte START or a busy refusal leaves register contents untouched.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam logic [3:0] ID_NIBBLE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ID,
    ST_RX_ADDR,
    ST_RX_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } bus_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int LAST = 8,
  parameter int W    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] ptr
);

  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (inc) begin
      ptr <= (ptr >= LAST_V) ? '0 : ptr + 1'b1;
    end
  end

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr == LAST_V) |=> (ptr == '0));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int LAST_ADDR   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = $clog2(LAST_ADDR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       dev_addr,
  input  logic             nv_busy,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_wr,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata,
  output logic             stop_pulse
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_state_e       state, ret_state;
  logic [7:0]       rx_sh, tx_sh;
  logic [3:0]       bcnt;
  logic             rd_pend;
  logic [PTR_W-1:0] ptr;

  logic quiet, byte_done, id_ok, do_wr, do_rd, ptr_load;

  always_comb begin
    quiet     = !start_det && !stop_det;
    byte_done = quiet && scl_fall && (bcnt == BITS_PER_BYTE);
    id_ok     = (rx_sh[7:1] == {ID_NIBBLE, dev_addr});
    ptr_load  = byte_done && (state == ST_RX_ADDR);
    do_wr     = byte_done && (state == ST_RX_DATA) && !nv_busy;
    do_rd     = (byte_done && (state == ST_RX_ID) && id_ok && rx_sh[0]) ||
                (quiet && scl_rise && (state == ST_MACK) && !sda_s);
  end

  i2c_reg_ptr #(.LAST(LAST_ADDR), .W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_sh[PTR_W-1:0]),
    .inc(do_wr || do_rd), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ret_state  <= ST_IDLE;
      rx_sh      <= '0;
      tx_sh      <= '0;
      bcnt       <= '0;
      sda_oe     <= 1'b0;
      rd_pend    <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      reg_wr     <= do_wr;
      reg_rd     <= do_rd;
      stop_pulse <= 1'b0;
      rd_pend    <= reg_rd;
      if (do_wr || do_rd) reg_addr <= ptr;
      if (do_wr) reg_wdata <= rx_sh;
      if (rd_pend) tx_sh <= reg_rdata;

      if (stop_det) begin
        state      <= ST_IDLE;
        sda_oe     <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_det) begin
        state  <= ST_RX_ID;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX_ID, ST_RX_ADDR, ST_RX_DATA: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[6:0], sda_s};
              bcnt  <= bcnt + 4'd1;
            end else if (byte_done) begin
              bcnt <= '0;
              if (state == ST_RX_ID) begin
                if (id_ok) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= rx_sh[0] ? ST_TX : ST_RX_ADDR;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_RX_ADDR || !nv_busy) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                ret_state <= ST_RX_DATA;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= ret_state;
              if (ret_state == ST_TX) begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                bcnt   <= 4'd1;
              end else begin
                sda_oe <= 1'b0;
                bcnt   <= '0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == BITS_PER_BYTE) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                bcnt   <= bcnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                state     <= ST_ACK;
                ret_state <= ST_TX;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe);

  // R6
  no_write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(nv_busy));

  // R7
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (state == ST_IDLE && !sda_oe));

  // R9
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;

  localparam int H = 12;
  localparam logic [2:0] DEV = 3'b101;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_5A, 12'h1_A5, 12'h4_FF, 12'h8_81, 12'h6_3C, 12'h2_C3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic nv_busy = 1'b0;
  logic sda_oe, reg_wr, reg_rd, stop_pulse;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] rdata_q;
  logic sda_line;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stop_cnt = 0;
  int wr_cnt = 0;
  int both_cnt = 0;
  int oe_viol = 0;
  logic prev_oe;
  logic [7:0] mem [16];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regport u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(DEV), .nv_busy(nv_busy), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(rdata_q), .stop_pulse(stop_pulse)
  );

  // register controller model and bus monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      rdata_q <= 8'h00;
      prev_oe <= 1'b0;
    end else begin
      if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
      if (reg_rd) rdata_q <= mem[reg_addr];
      if (stop_pulse) stop_cnt <= stop_cnt + 1;
      if (reg_wr && reg_rd) both_cnt <= both_cnt + 1;
      if (sda_oe != prev_oe && scl_m) oe_viol <= oe_viol + 1;
      prev_oe <= sda_oe;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired: act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = !sda_line;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  // data bytes packed lowest byte first
  task automatic i2c_write(input logic [2:0] dsel, input logic [7:0] addr, input int n,
                           input logic [23:0] d, output logic a_id, output logic a_last);
    logic a;
    i2c_start();
    send_byte({4'b1010, dsel, 1'b0}, a_id);
    send_byte(addr, a);
    a_last = a;
    for (int k = 0; k < n; k++) send_byte(d[8*k +: 8], a_last);
    i2c_stop();
  endtask

  task automatic i2c_read(input logic [7:0] addr, input int n, output logic [23:0] q, output logic ok);
    logic a0, a1, a2;
    logic [7:0] b;
    q = '0;
    i2c_start();
    send_byte({4'b1010, DEV, 1'b0}, a0);
    send_byte(addr, a1);
    i2c_start();
    send_byte({4'b1010, DEV, 1'b1}, a2);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      q[8*k +: 8] = b;
    end
    i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    logic a_id, a_last, ok;
    logic [23:0] q;
    int s0, w0;

    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_wr == 1'b0 && reg_rd == 1'b0 && stop_pulse == 1'b0, "R1 strobes idle",
        {reg_wr, reg_rd, stop_pulse}, 0);

    // table walk: single write then single read back (R3, R5)
    for (int v = 0; v < NVEC; v++) begin
      i2c_write(DEV, {4'h0, VEC[v][11:8]}, 1, {16'h0, VEC[v][7:0]}, a_id, a_last);
      chk(a_id && a_last, "R3 write ACKs", {a_id, a_last}, 2'b11);
      i2c_read({4'h0, VEC[v][11:8]}, 1, q, ok);
      chk(ok && q[7:0] == VEC[v][7:0], "R5 read back", q[7:0], VEC[v][7:0]);
    end

    // R2 wrong strap bits: no ACK, line stays released for the next byte
    i2c_start();
    send_byte({4'b1010, 3'b001, 1'b0}, a_id);
    chk(!a_id, "R2 mismatched ID not ACKed", a_id, 0);
    send_byte(8'h00, a_last);
    chk(!a_last, "R2 ignored until START", a_last, 0);
    i2c_stop();
    chk(mem[0] == 8'h5A, "R2 register untouched", mem[0], 8'h5A);

    // R7 STOP pulse count
    s0 = stop_cnt;
    i2c_write(DEV, 8'h05, 1, 24'h0000_77, a_id, a_last);
    repeat (4) @(negedge clk);
    chk(stop_cnt == s0 + 1, "R7 one stop_pulse per STOP", stop_cnt, s0 + 1);
    chk(sda_oe == 1'b0, "R7 SDA released after STOP", sda_oe, 0);

    // R4 write stream across the wrap: 7,8,0
    i2c_write(DEV, 8'h07, 3, 24'h33_22_11, a_id, a_last);
    chk(mem[7] == 8'h11, "R3 burst first byte", mem[7], 8'h11);
    chk(mem[8] == 8'h22, "R4 burst at last address", mem[8], 8'h22);
    chk(mem[0] == 8'h33, "R4 write wraps to 0", mem[0], 8'h33);

    // R4/R5 read stream across the wrap: 8,0,1
    i2c_read(8'h08, 3, q, ok);
    chk(q == 24'hA5_33_22, "R4 read wraps to 0", q, 24'hA5_33_22);
    chk(ok, "R5 read header ACKed", ok, 1);

    // R6 busy refusal
    nv_busy = 1'b1;
    w0 = wr_cnt;
    i2c_write(DEV, 8'h02, 1, 24'h0000_55, a_id, a_last);
    chk(!a_last, "R6 data NACKed while busy", a_last, 0);
    chk(wr_cnt == w0, "R6 no write strobe while busy", wr_cnt, w0);
    nv_busy = 1'b0;
    i2c_read(8'h02, 1, q, ok);
    chk(q[7:0] == 8'hC3, "R6 register unchanged", q[7:0], 8'hC3);

    // R8 START in the middle of a byte
    i2c_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    i2c_write(DEV, 8'h03, 1, 24'h0000_3C, a_id, a_last);
    chk(a_id && a_last, "R8 restart ACKs", {a_id, a_last}, 2'b11);
    chk(mem[3] == 8'h3C, "R8 write after abort", mem[3], 8'h3C);

    // R9 / R10 monitors over the whole run
    chk(oe_viol == 0, "R9 SDA changed while SCL high", oe_viol, 0);
    chk(both_cnt == 0, "R10 overlapping strobes", both_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule